// File: doc/BRIEF.md
# Matrix Keypad Scanner with Toggle Handshake

This block reads a 4x4 matrix keypad. It pulls one column low at a time and watches four pulled-up row lines, so a row that reads low shows which key is closed. Columns are stepped on a slow scan tick, which a divider inside the block makes from the master clock. When a row leaves its idle all-ones value, the block keeps that row pattern and waits one full tick. It then checks the rows again on the same column. A press that is still there is turned into a 4-bit key code.

The code goes to a slow host over a 4-bit bus that holds its value. Next to the bus is a single flag line that changes level once for every accepted press. The host polls both lines. It treats any change of the flag as "a new key is on the bus", so it needs no strobe it might miss and no ready line back to the block. A key that stays down is accepted again every three ticks. Each repeat flips the flag and leaves the same code on the bus.

Top module: `keypad_scanner`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets key_code to 0 and key_toggle to 0, and sets col_n to 4'b1110, which drives column 0 only.
- R2: The scan tick occurs once every 2*HALF_DIV master clock cycles, which is 20,000 cycles by default. The first tick comes 2*HALF_DIV cycles after reset is released.
- R3: Exactly one bit of col_n is 0 at all times, and bit c low selects column c. col_n changes only on a scan tick. While the rows read all-ones, each tick advances the column 0→1→2→3→0.
- R4: If the synchronized rows are not all-ones at a tick while scanning, that row pattern is captured and the block pauses for one tick. Column movement stops for the pause tick and for the following confirm tick.
- R5: At the confirm tick, if the synchronized rows equal the captured pattern, the key is accepted. key_code takes the new code and key_toggle inverts on the clock edge of that tick. Scanning then resumes on the same column.
- R6: At the confirm tick, if the rows differ from the captured pattern, nothing is accepted. key_code and key_toggle keep their values, and scanning resumes.
- R7: The code for row r and column c is nibble r*4+c of the sequence 1,2,3,A, 4,5,6,B, 7,8,9,C, E,0,F,D, counted from the left. Keys with a digit label give that digit, and keys with a letter label give 0xA–0xF. If several rows are low, the lowest-numbered low row sets the code.
- R8: row_n passes through two flip-flops. The decision at a tick edge therefore uses the row_n value sampled two clock edges earlier. A pulse seen only at the edge just before the tick is ignored.
- R9: key_code changes only when a key is accepted, and it is never cleared between presses. A key held down is accepted again every three ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| row_n | input | 4 | Keypad row lines, active low, pulled up |
| col_n | output | 4 | Column drive, active low, one column at a time |
| key_code | output | 4 | Code of the most recently accepted key |
| key_toggle | output | 1 | Inverts once per accepted key |

## Verification
Every result in this block lands on the clock edge of a scan tick. The row value that counts is the one sampled two edges before that tick. A column step, a capture, or an acceptance is therefore visible one edge after tick T and depends on row_n at edge T-2. The bench models this with its own edge counter and a two-deep row queue. It compares col_n, key_code and key_toggle with that model at every falling edge. Its directed checks time row pulses against the edge count: a pulse at T-1 must be missed and a pulse at T-2 must be captured.

// File: rtl/kps_pkg.sv
package kps_pkg;
  localparam int KP_ROWS   = 4;
  localparam int KP_COLS   = 4;
  localparam int KEY_W     = 4;
  localparam int ROW_IDX_W = $clog2(KP_ROWS);
  localparam int COL_IDX_W = $clog2(KP_COLS);

  typedef enum logic [1:0] {
    ST_SCAN    = 2'd0,
    ST_PAUSE   = 2'd1,
    ST_CONFIRM = 2'd2
  } scan_st_e;

  // next column in the scan ring
  function automatic logic [COL_IDX_W-1:0] next_col(input logic [COL_IDX_W-1:0] c);
    if (c == COL_IDX_W'(KP_COLS - 1)) next_col = '0;
    else                             next_col = c + 1'b1;
  endfunction

  // lowest-numbered row that reads low (active-low lines)
  function automatic logic [ROW_IDX_W-1:0] first_low_row(input logic [KP_ROWS-1:0] rn);
    first_low_row = '0;
    for (int i = KP_ROWS - 1; i >= 0; i--) begin
      if (!rn[i]) first_low_row = ROW_IDX_W'(i);
    end
  endfunction

  // key label at row r, column c of a hex keypad
  function automatic logic [KEY_W-1:0] key_of(input logic [ROW_IDX_W-1:0] r,
                                               input logic [COL_IDX_W-1:0] c);
    case ({r, c})
      4'h0: key_of = 4'h1;
      4'h1: key_of = 4'h2;
      4'h2: key_of = 4'h3;
      4'h3: key_of = 4'hA;
      4'h4: key_of = 4'h4;
      4'h5: key_of = 4'h5;
      4'h6: key_of = 4'h6;
      4'h7: key_of = 4'hB;
      4'h8: key_of = 4'h7;
      4'h9: key_of = 4'h8;
      4'hA: key_of = 4'h9;
      4'hB: key_of = 4'hC;
      4'hC: key_of = 4'hE;
      4'hD: key_of = 4'h0;
      4'hE: key_of = 4'hF;
      default: key_of = 4'hD;
    endcase
  endfunction
endpackage

// File: rtl/kps_tick_div.sv
module kps_tick_div #(
  parameter int HALF_DIV = 10000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // one pulse per full divided period
  assign tick = (cnt == LAST) && phase;
endmodule

// File: rtl/kps_row_sync.sv
module kps_row_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/kps_scan_fsm.sv
module kps_scan_fsm
  import kps_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [KP_ROWS-1:0]   rows_s,
  output logic [COL_IDX_W-1:0] col_idx,
  output logic [KEY_W-1:0]     key_code,
  output logic                 key_toggle,
  output scan_st_e             state,
  output logic                 capture,
  output logic                 accept
);
  logic [KP_ROWS-1:0] cap_rows;
  logic               rows_idle;

  assign rows_idle = &rows_s;
  assign capture   = tick && (state == ST_SCAN) && !rows_idle;
  assign accept    = tick && (state == ST_CONFIRM) && (rows_s == cap_rows);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SCAN;
      col_idx    <= '0;
      cap_rows   <= '1;
      key_code   <= '0;
      key_toggle <= 1'b0;
    end else if (tick) begin
      case (state)
        ST_SCAN: begin
          if (!rows_idle) begin
            cap_rows <= rows_s;
            state    <= ST_PAUSE;
          end else begin
            col_idx <= next_col(col_idx);
          end
        end
        ST_PAUSE: state <= ST_CONFIRM;
        ST_CONFIRM: begin
          state <= ST_SCAN;
          if (rows_s == cap_rows) begin
            key_code   <= key_of(first_low_row(cap_rows), col_idx);
            key_toggle <= ~key_toggle;
          end
        end
        default: state <= ST_SCAN;
      endcase
    end
  end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kps_pkg::*;
#(
  parameter int HALF_DIV = 10000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [KP_ROWS-1:0] row_n,
  output logic [KP_COLS-1:0] col_n,
  output logic [KEY_W-1:0]   key_code,
  output logic               key_toggle
);
  logic                 tick_w;
  logic [KP_ROWS-1:0]   rows_s;
  logic [COL_IDX_W-1:0] col_idx;
  scan_st_e             st_w;
  logic                 capture_w;
  logic                 accept_w;

  kps_tick_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .tick(tick_w)
  );

  kps_row_sync #(.W(KP_ROWS), .STAGES(2)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (row_n),
    .q  (rows_s)
  );

  kps_scan_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_w),
    .rows_s    (rows_s),
    .col_idx   (col_idx),
    .key_code  (key_code),
    .key_toggle(key_toggle),
    .state     (st_w),
    .capture   (capture_w),
    .accept    (accept_w)
  );

  for (genvar c = 0; c < KP_COLS; c++) begin : g_col
    assign col_n[c] = (col_idx != COL_IDX_W'(c));
  end
endmodule

// File: rtl/kps_checker.sv
module kps_checker
  import kps_pkg::*;
#(
  parameter int HALF_DIV = 10000
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               capture,
  input logic               accept,
  input scan_st_e           st,
  input logic [KP_COLS-1:0] col_n,
  input logic [KEY_W-1:0]   key_code,
  input logic               key_toggle
);
  localparam int PERIOD = 2 * HALF_DIV;

  int gap;
  always_ff @(posedge clk) begin
    if (rst || tick) gap <= 0;
    else             gap <= gap + 1;
  end

  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (rst)
    tick |-> gap == PERIOD - 1);                                      // R2
  AST_ONE_COL_LOW: assert property (@(posedge clk) disable iff (rst)
    $countones(~col_n) == 1);                                         // R3
  AST_COL_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(col_n));                                        // R3
  AST_COL_HELD_CHECK: assert property (@(posedge clk) disable iff (rst)
    (tick && st != ST_SCAN) |=> $stable(col_n));                      // R4
  AST_CAPTURE_PAUSE: assert property (@(posedge clk) disable iff (rst)
    capture |=> st == ST_PAUSE);                                      // R4
  AST_TOGGLE_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> key_toggle != $past(key_toggle));                      // R5
  AST_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(key_toggle));                                 // R6
  AST_KEY_HELD: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(key_code));                                   // R9
endmodule

bind keypad_scanner kps_checker #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick_w),
  .capture   (capture_w),
  .accept    (accept_w),
  .st        (st_w),
  .col_n     (col_n),
  .key_code  (key_code),
  .key_toggle(key_toggle)
);

// File: tb/keypad_scanner_bench.sv
module keypad_scanner_bench;
  localparam int HALF = 3;
  localparam int PER  = 2 * HALF;
  localparam logic [63:0] LAYOUT = 64'h123A_456B_789C_E0FD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] row_n, col_n, key_code;
  logic key_toggle;
  logic [15:0] pressed = '0;
  logic force_en = 1'b0;
  logic [3:0] force_rows = 4'hF;

  always #5 clk = ~clk;

  // keypad emulation: a closed key shorts its row to its driven column
  always_comb begin
    logic [3:0] rows;
    rows = 4'hF;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (pressed[r*4+c] && !col_n[c]) rows[r] = 1'b0;
    row_n = force_en ? force_rows : rows;
  end

  keypad_scanner #(.HALF_DIV(HALF)) u_keypad_scanner (
    .clk(clk), .rst(rst), .row_n(row_n), .col_n(col_n),
    .key_code(key_code), .key_toggle(key_toggle)
  );

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  function automatic logic [3:0] layout_code(int r, int c);
    return LAYOUT[(63 - 4*(r*4+c)) -: 4];
  endfunction

  function automatic int low_row(logic [3:0] v);
    for (int i = 0; i < 4; i++) if (!v[i]) return i;
    return 0;
  endfunction

  function automatic int col_of(logic [3:0] cn);
    for (int i = 0; i < 4; i++) if (!cn[i]) return i;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: edge counter, two-deep row queue, three phases
  int m_edges, m_state, m_col;
  logic [3:0] m_cap, m_key;
  logic m_tog;
  logic [3:0] q[$];

  always @(posedge clk) begin
    logic [3:0] rs;
    if (rst) begin
      m_edges = 0; m_state = 0; m_col = 0; m_cap = 4'hF;
      m_key = 4'h0; m_tog = 1'b0;
      q.delete(); q.push_back(4'hF); q.push_back(4'hF);
    end else begin
      rs = q.pop_front();
      q.push_back(row_n);
      if (m_edges % PER == PER - 1) begin
        if (m_state == 0) begin
          if (rs != 4'hF) begin m_cap = rs; m_state = 1; end
          else m_col = (m_col + 1) % 4;
        end else if (m_state == 1) begin
          m_state = 2;
        end else begin
          if (rs == m_cap) begin
            m_key = layout_code(low_row(m_cap), m_col);
            m_tog = ~m_tog;
          end
          m_state = 0;
        end
      end
      m_edges++;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [3:0] ecol;
      ecol = ~(4'b0001 << m_col);
      check(col_n == ecol && key_code == m_key && key_toggle == m_tog, cur_req,
            "per-cycle {col,key,tog}", {23'd0, col_n, key_code, key_toggle},
            {23'd0, ecol, m_key, m_tog});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic wait_ticks(int n);
    repeat (n * PER) @(negedge clk);
  endtask

  task automatic wait_state(int s);
    for (int i = 0; i < 40 * PER && m_state != s; i++) @(negedge clk);
  endtask

  task automatic press_and_check(logic [15:0] keys, logic [3:0] exp, string req);
    logic t0;
    t0 = key_toggle;
    pressed = keys;
    for (int i = 0; i < 40 * PER && key_toggle == t0; i++) @(negedge clk);
    pressed = '0;
    check(key_toggle != t0, "R5", "toggle after press", key_toggle, ~t0);
    check(key_code == exp, req, "key code", key_code, exp);
    wait_ticks(3);
  endtask

  initial begin
    logic [3:0] c0, c1;
    logic t0;
    logic [3:0] k0;
    int n, flips;
    repeat (4) @(negedge clk);
    check(col_n == 4'b1110, "R1", "reset col_n", col_n, 4'b1110);
    check(key_code == 4'h0, "R1", "reset key_code", key_code, 0);
    check(key_toggle == 1'b0, "R1", "reset key_toggle", key_toggle, 0);
    rst = 1'b0;

    // R2 / R3: idle scan timing and ring order
    cur_req = "R3";
    c0 = col_n; n = 0;
    while (col_n == c0 && n < 100) begin @(negedge clk); n++; end
    check(n == PER, "R2", "cycles to first step", n, PER);
    c1 = col_n; n = 0;
    while (col_n == c1 && n < 100) begin @(negedge clk); n++; end
    check(n == PER, "R2", "tick spacing", n, PER);
    check(col_n == 4'b1011, "R3", "column after two steps", col_n, 4'b1011);
    wait_ticks(2);
    check(col_n == 4'b1110, "R3", "column wraps", col_n, 4'b1110);

    // R5 / R7: every key
    cur_req = "R7";
    for (int k = 0; k < 16; k++)
      press_and_check(16'(1) << k, layout_code(k / 4, k % 4), "R7");

    // R7: two rows on one column, lower row wins
    press_and_check((16'(1) << 6) | (16'(1) << 14), 4'h6, "R7");

    // R4: column held through pause and confirm
    cur_req = "R4";
    force_en = 1'b1; force_rows = 4'b1011;
    wait_state(1);
    c0 = col_n;
    wait_state(2);
    check(col_n == c0, "R4", "column held in confirm", col_n, c0);
    wait_state(0);
    check(key_code == layout_code(2, col_of(c0)), "R5", "forced row2 key",
          key_code, layout_code(2, col_of(c0)));
    force_rows = 4'hF;
    wait_ticks(3);

    // R6: bounce rejected
    cur_req = "R6";
    force_rows = 4'b0111;
    wait_state(1);
    force_rows = 4'hF;
    t0 = key_toggle; k0 = key_code;
    wait_state(0);
    wait_ticks(2);
    check(key_toggle == t0, "R6", "toggle after bounce", key_toggle, t0);
    check(key_code == k0, "R6", "key after bounce", key_code, k0);

    // R9: held key repeats every three ticks
    cur_req = "R9";
    force_rows = 4'b1101;
    t0 = key_toggle; flips = 0;
    for (int i = 0; i < 30 * PER; i++) begin
      @(negedge clk);
      if (key_toggle != t0) begin flips++; t0 = key_toggle; end
    end
    force_rows = 4'hF;
    check(flips >= 9 && flips <= 10, "R9", "repeat count in 30 ticks", flips, 10);
    k0 = key_code;
    wait_ticks(4);
    check(key_code == k0, "R9", "key held after release", key_code, k0);

    // R8: pulse only at edge T-1 is missed, pulse at edge T-2 is captured
    cur_req = "R8";
    wait_state(0);
    wait_ticks(3);
    while (m_edges % PER != PER - 2) @(negedge clk);
    c0 = col_n;
    force_rows = 4'b1110;
    @(negedge clk);
    force_rows = 4'hF;
    @(negedge clk);
    check(col_n != c0, "R8", "late pulse ignored, column moved", col_n, ~c0);
    while (m_edges % PER != PER - 3) @(negedge clk);
    c0 = col_n;
    force_rows = 4'b1110;
    @(negedge clk);
    force_rows = 4'hF;
    repeat (2) @(negedge clk);
    check(col_n == c0, "R8", "early pulse captured, column held", col_n, c0);
    wait_ticks(4);
    force_en = 1'b0;
    finish_run();
  end
endmodule